// File: doc/BRIEF.md
# Frame-Mapped Generic Framing Transmitter

This block wraps client Ethernet frames into a frame-mapped generic framing byte stream for a byte-wide payload sink. A client source announces a pending frame and its byte count. The block then pulls the frame one byte per payload slot. Each emitted frame starts with a four-byte core header: the length indicator and its header check, covered by a fixed XOR mask. A four-byte payload header follows, made of a programmable 16-bit type and its check. The client bytes come next, and an optional CRC-32 frame check sequence closes the frame. Every byte after the core header passes through a self-synchronous x^43+1 scrambler. When no client frame is pending at a frame boundary, the block sends four-byte idle frames.

The sink offers one byte slot per cycle in which `sink_en` is high, and the block advances only in those cycles. The emitted byte is registered and appears on `out_byte`, with `out_stb`, one cycle after its slot. The source behaves like a show-ahead FIFO: `pkt_byte` must be valid in every cycle, and a byte counts as consumed in each cycle where `pkt_take` is high. Configuration inputs are held static while a frame is in flight. The only exception is `cfg_scr_off`, which is evaluated byte by byte.

Top module: `gfpf_tx_encap`

## Requirements
- R1: While reset is applied and until the first slot after it, `out_stb`, `out_sof`, `out_byte` and `pkt_take` are all zero. The scrambler history starts at zero, and the first slot after reset is a frame boundary.
- R2: The block advances one byte per cycle with `sink_en` high. In the next cycle `out_stb` equals that cycle's `sink_en`. In a cycle without a slot, `out_byte` keeps its value and no byte is taken.
- R3: If `pkt_pending` is low at a frame boundary slot, the block emits an idle frame: the bytes 0xB6, 0xAB, 0x31, 0xE0 (length 0 and check 0, after the mask). `out_sof` is high on the first of these bytes.
- R4: A client frame of L bytes starts with a length indicator of L+8, or L+4 when the FCS is off, sent most significant byte first. Two header-check bytes follow. The check is CRC-16 with generator x^16+x^12+x^5+1, initial value zero, fed MSB first over the two length bytes. These four bytes are XORed in order with 0xB6, 0xAB, 0x31, 0xE0, and `out_sof` marks the first of them.
- R5: After the core header come `cfg_type_hi`, `cfg_type_lo` and their CRC-16 check, computed like the one in R4. Then the L client bytes follow in order, with `pkt_take` high in exactly the L slots that carry them.
- R6: With `cfg_laps` low, the FCS is CRC-32 over the client bytes only, with generator 0x04C11DB7. It starts from all ones, is fed MSB first, is complemented at the end, and is sent most significant byte first.
- R7: With `cfg_laps` high, the FCS is computed LSB first with the reflected generator 0xEDB88320 over the same bytes, starting from all ones and complemented at the end. Its least significant byte is sent first, and each byte goes out with its bit order reversed.
- R8: With `cfg_fcs_off` high, no FCS bytes are sent and the length indicator excludes them.
- R9: Every byte after the core header is scrambled MSB first, with each output bit equal to the input bit XOR the output bit 43 positions earlier. The history carries across frames. Core headers and idle frames neither use nor advance it.
- R10: With `cfg_scr_off` high, bytes after the core header go out unscrambled and the scrambler history is held. The core header mask is still applied.
- R11: The pending flag, `pkt_len`, `cfg_fcs_off` and `cfg_laps` are sampled at the first core header slot. A frame that is pending when the previous one ends starts in the very next slot, with a header that matches its own length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sink_en | input | 1 | Sink offers a byte slot this cycle |
| pkt_pending | input | 1 | A client frame is ready |
| pkt_len | input | LEN_W | Client frame byte count (at least 1) |
| pkt_byte | input | 8 | Current client byte (show-ahead) |
| pkt_take | output | 1 | Current client byte consumed this cycle |
| cfg_type_hi | input | 8 | Type field, upper byte |
| cfg_type_lo | input | 8 | Type field, lower byte |
| cfg_fcs_off | input | 1 | Omit the frame check sequence |
| cfg_laps | input | 1 | Reflected, bit-reversed FCS mode |
| cfg_scr_off | input | 1 | Bypass the payload scrambler |
| out_byte | output | 8 | Emitted stream byte |
| out_stb | output | 1 | `out_byte` carries a new byte |
| out_sof | output | 1 | Byte is the first of a frame's core header |

## Verification
Two things can coincide in one slot: the boundary decision between an idle frame and a client frame, and a change to the scrambler-inhibit input. The bench runs one frame with scrambling off and lets two idle frames pass. Then, in the cycle before the slot that opens the next boundary, it raises a new pending frame and clears the inhibit. The stream is judged against a model whose scrambler history must still be zero when the second frame starts. Stalled slots are also placed in the middle of back-to-back frames, to show that neither the byte count nor the scrambler history moves without a slot.

// File: rtl/gfp_tx_pkg.sv
package gfp_tx_pkg;

  localparam int PLI_W = 16;
  localparam logic [15:0] HEC_POLY = 16'h1021;
  localparam logic [31:0] FCS_POLY = 32'h04C11DB7;
  localparam logic [31:0] FCS_POLY_REF = 32'hEDB88320;
  localparam logic [31:0] CORE_MASK = 32'hB6AB31E0;

  typedef enum logic [1:0] {
    ST_CORE = 2'd0,
    ST_PHDR = 2'd1,
    ST_PAY  = 2'd2,
    ST_FCS  = 2'd3
  } gfp_st_e;

  function automatic logic [15:0] hec16(input logic [7:0] b_hi, input logic [7:0] b_lo);
    logic [15:0] c;
    logic [15:0] d;
    logic fb;
    c = '0;
    d = {b_hi, b_lo};
    for (int i = 15; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ HEC_POLY;
    end
    return c;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] k);
    logic [7:0] r;
    case (k)
      2'd0:    r = w[31:24];
      2'd1:    r = w[23:16];
      2'd2:    r = w[15:8];
      default: r = w[7:0];
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gfpf_tx_seq.sv
module gfpf_tx_seq
  import gfp_tx_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sink_en,
  input  logic             pkt_pending,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [7:0]       pkt_byte,
  input  logic [7:0]       cfg_type_hi,
  input  logic [7:0]       cfg_type_lo,
  input  logic             cfg_fcs_off,
  input  logic             cfg_laps,
  input  logic [31:0]      fcs_word,
  output logic [7:0]       raw_byte,
  output logic             area_byte,
  output logic             frame_start,
  output logic             pkt_take,
  output logic             crc_init,
  output logic             laps_mode
);

  gfp_st_e          st_q, st_d;
  logic [1:0]       idx_q, idx_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [PLI_W-1:0] pli_q, pli_d;
  logic             idle_q, idle_d;
  logic             nofcs_q, nofcs_d;
  logic             laps_q, laps_d;

  logic             at_bound;
  logic [PLI_W-1:0] live_pli;
  logic [PLI_W-1:0] cur_pli;
  logic [31:0]      core_word;
  logic [31:0]      type_word;

  assign at_bound  = (st_q == ST_CORE) && (idx_q == 2'd0);
  assign live_pli  = pkt_pending ? (PLI_W'(pkt_len) + (cfg_fcs_off ? 16'd4 : 16'd8)) : '0;
  assign cur_pli   = at_bound ? live_pli : pli_q;
  assign core_word = {cur_pli, hec16(cur_pli[15:8], cur_pli[7:0])} ^ CORE_MASK;
  assign type_word = {cfg_type_hi, cfg_type_lo, hec16(cfg_type_hi, cfg_type_lo)};

  always_comb begin
    case (st_q)
      ST_CORE: raw_byte = pick_byte(core_word, idx_q);
      ST_PHDR: raw_byte = pick_byte(type_word, idx_q);
      ST_PAY:  raw_byte = pkt_byte;
      default: raw_byte = pick_byte(fcs_word, idx_q);
    endcase
  end

  assign area_byte   = (st_q != ST_CORE);
  assign frame_start = at_bound;
  assign pkt_take    = sink_en && (st_q == ST_PAY);
  assign crc_init    = sink_en && at_bound;
  assign laps_mode   = laps_q;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    pli_d   = pli_q;
    idle_d  = idle_q;
    nofcs_d = nofcs_q;
    laps_d  = laps_q;
    if (sink_en) begin
      case (st_q)
        ST_CORE: begin
          if (idx_q == 2'd0) begin
            pli_d   = live_pli;
            idle_d  = !pkt_pending;
            len_d   = pkt_len;
            nofcs_d = cfg_fcs_off;
            laps_d  = cfg_laps;
          end
          idx_d = idx_q + 2'd1;
          if (idx_q == 2'd3) st_d = idle_q ? ST_CORE : ST_PHDR;
        end
        ST_PHDR: begin
          idx_d = idx_q + 2'd1;
          if (idx_q == 2'd3) begin
            st_d  = ST_PAY;
            cnt_d = '0;
          end
        end
        ST_PAY: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == len_q - 1'b1) begin
            cnt_d = '0;
            st_d  = nofcs_q ? ST_CORE : ST_FCS;
          end
        end
        default: begin
          idx_d = idx_q + 2'd1;
          if (idx_q == 2'd3) st_d = ST_CORE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_CORE;
      idx_q   <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      pli_q   <= '0;
      idle_q  <= 1'b1;
      nofcs_q <= 1'b0;
      laps_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      pli_q   <= pli_d;
      idle_q  <= idle_d;
      nofcs_q <= nofcs_d;
      laps_q  <= laps_d;
    end
  end

endmodule

// File: rtl/gfpf_tx_fcs.sv
module gfpf_tx_fcs
  import gfp_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic        laps,
  input  logic [7:0]  data,
  output logic [31:0] fcs_word
);

  logic [31:0] crc_q, crc_d;
  logic [31:0] stepped;
  logic [31:0] fin;
  logic        fb;

  always_comb begin
    stepped = crc_q;
    fb      = 1'b0;
    if (laps) begin
      for (int i = 0; i < 8; i++) begin
        fb      = stepped[0] ^ data[i];
        stepped = {1'b0, stepped[31:1]};
        if (fb) stepped = stepped ^ FCS_POLY_REF;
      end
    end else begin
      for (int i = 7; i >= 0; i--) begin
        fb      = stepped[31] ^ data[i];
        stepped = {stepped[30:0], 1'b0};
        if (fb) stepped = stepped ^ FCS_POLY;
      end
    end
  end

  always_comb begin
    if (init)     crc_d = '1;
    else if (upd) crc_d = stepped;
    else          crc_d = crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

  assign fin = ~crc_q;
  assign fcs_word = laps ? {rev8(fin[7:0]), rev8(fin[15:8]), rev8(fin[23:16]), rev8(fin[31:24])}
                         : fin;

endmodule

// File: rtl/gfpf_tx_scr.sv
module gfpf_tx_scr #(
  parameter int TAP = 43
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  logic       scr_act,
  input  logic       sof_in,
  input  logic [7:0] raw,
  output logic [7:0] out_byte,
  output logic       out_stb,
  output logic       out_sof
);

  logic [TAP-1:0] hist_q, hist_d, h;
  logic [7:0]     sbyte;
  logic [7:0]     byte_d;

  always_comb begin
    h     = hist_q;
    sbyte = '0;
    for (int i = 7; i >= 0; i--) begin
      sbyte[i] = raw[i] ^ h[TAP-1];
      h = {h[TAP-2:0], sbyte[i]};
    end
  end

  always_comb begin
    hist_d = hist_q;
    byte_d = out_byte;
    if (stb) begin
      byte_d = scr_act ? sbyte : raw;
      if (scr_act) hist_d = h;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= '0;
      out_byte <= '0;
      out_stb  <= 1'b0;
      out_sof  <= 1'b0;
    end else begin
      hist_q   <= hist_d;
      out_byte <= byte_d;
      out_stb  <= stb;
      out_sof  <= stb && sof_in;
    end
  end

endmodule

// File: rtl/gfpf_tx_encap.sv
module gfpf_tx_encap #(
  parameter int LEN_W = 12,
  parameter int SCR_TAP = 43
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sink_en,
  input  logic             pkt_pending,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [7:0]       pkt_byte,
  output logic             pkt_take,
  input  logic [7:0]       cfg_type_hi,
  input  logic [7:0]       cfg_type_lo,
  input  logic             cfg_fcs_off,
  input  logic             cfg_laps,
  input  logic             cfg_scr_off,
  output logic [7:0]       out_byte,
  output logic             out_stb,
  output logic             out_sof
);

  logic [1:0]  rst_pipe;
  logic        rst_core_n;
  logic [7:0]  raw_byte;
  logic        area_byte;
  logic        frame_start;
  logic        crc_init;
  logic        laps_mode;
  logic [31:0] fcs_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  gfpf_tx_seq #(.LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .sink_en     (sink_en),
    .pkt_pending (pkt_pending),
    .pkt_len     (pkt_len),
    .pkt_byte    (pkt_byte),
    .cfg_type_hi (cfg_type_hi),
    .cfg_type_lo (cfg_type_lo),
    .cfg_fcs_off (cfg_fcs_off),
    .cfg_laps    (cfg_laps),
    .fcs_word    (fcs_word),
    .raw_byte    (raw_byte),
    .area_byte   (area_byte),
    .frame_start (frame_start),
    .pkt_take    (pkt_take),
    .crc_init    (crc_init),
    .laps_mode   (laps_mode)
  );

  gfpf_tx_fcs u_fcs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .init     (crc_init),
    .upd      (pkt_take),
    .laps     (laps_mode),
    .data     (pkt_byte),
    .fcs_word (fcs_word)
  );

  gfpf_tx_scr #(.TAP(SCR_TAP)) u_scr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .stb      (sink_en),
    .scr_act  (area_byte && !cfg_scr_off),
    .sof_in   (frame_start),
    .raw      (raw_byte),
    .out_byte (out_byte),
    .out_stb  (out_stb),
    .out_sof  (out_sof)
  );

endmodule

// File: rtl/gfpf_tx_encap_chk.sv
module gfpf_tx_encap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sink_en,
  input logic       pkt_take,
  input logic [7:0] out_byte,
  input logic       out_stb,
  input logic       out_sof
);

  // R2: a slot yields a strobed byte one cycle later
  assert_slot_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sink_en |=> out_stb);

  // R2: no slot, no strobe
  assert_no_slot_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sink_en |=> !out_stb);

  // R2: emitted byte holds without a slot
  assert_byte_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sink_en |=> $stable(out_byte));

  // R3: frame start marker only on a strobed byte
  assert_sof_strobed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_stb);

  // R5: a client byte is never the first byte of a frame
  assert_take_not_sof_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_take |=> (out_stb && !out_sof));

endmodule

bind gfpf_tx_encap gfpf_tx_encap_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .sink_en  (sink_en),
  .pkt_take (pkt_take),
  .out_byte (out_byte),
  .out_stb  (out_stb),
  .out_sof  (out_sof)
);

// File: tb/gfpf_tx_encap_tb.sv
module gfpf_tx_encap_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sink_en;
  logic        pkt_pending;
  logic [11:0] pkt_len;
  logic [7:0]  pkt_byte;
  logic        pkt_take;
  logic [7:0]  cfg_type_hi, cfg_type_lo;
  logic        cfg_fcs_off, cfg_laps, cfg_scr_off;
  logic [7:0]  out_byte;
  logic        out_stb, out_sof;

  always #4 clk = ~clk;

  gfpf_tx_encap u_dut (
    .clk(clk), .rst_n(rst_n), .sink_en(sink_en), .pkt_pending(pkt_pending),
    .pkt_len(pkt_len), .pkt_byte(pkt_byte), .pkt_take(pkt_take),
    .cfg_type_hi(cfg_type_hi), .cfg_type_lo(cfg_type_lo), .cfg_fcs_off(cfg_fcs_off),
    .cfg_laps(cfg_laps), .cfg_scr_off(cfg_scr_off),
    .out_byte(out_byte), .out_stb(out_stb), .out_sof(out_sof)
  );

  // client source model
  logic [7:0] src_mem [0:63];
  int fr_len [0:4];
  int fr_cnt;
  int src_rd, fr_idx, fr_byte;

  assign pkt_pending = (fr_idx < fr_cnt);
  assign pkt_len     = 12'(fr_len[(fr_idx > 4) ? 4 : fr_idx]);
  assign pkt_byte    = src_mem[src_rd & 63];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_rd <= 0; fr_idx <= 0; fr_byte <= 0;
    end else if (pkt_take) begin
      src_rd <= src_rd + 1;
      if (fr_byte == fr_len[(fr_idx > 4) ? 4 : fr_idx] - 1) begin
        fr_idx <= fr_idx + 1; fr_byte <= 0;
      end else fr_byte <= fr_byte + 1;
    end
  end

  int n_total = 0, n_fail = 0;
  logic [7:0] cap_b [0:511];
  logic       cap_s [0:511];
  int cap_n;
  logic [7:0] exp_b [0:511];
  logic       exp_s [0:511];
  int         exp_r [0:511];
  int exp_n;
  logic [42:0] m_hist;
  int tag_core, tag_area;
  logic prev_en;
  logic [7:0] last_byte;
  int stb_err, hold_err;

  function automatic string rname(input int k);
    case (k)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_hec(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] c = 16'h0;
    logic [15:0] d = {a, b};
    for (int i = 15; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [7:0] m_rev(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic push(input logic [7:0] b, input logic s, input bit scr, input int req);
    logic [7:0] o = b;
    if (scr) begin
      for (int i = 7; i >= 0; i--) begin
        o[i] = b[i] ^ m_hist[42];
        m_hist = {m_hist[41:0], o[i]};
      end
    end
    exp_b[exp_n] = o; exp_s[exp_n] = s; exp_r[exp_n] = req; exp_n++;
  endtask

  task automatic add_idle();
    push(8'hB6, 1'b1, 1'b0, 3); push(8'hAB, 1'b0, 1'b0, 3);
    push(8'h31, 1'b0, 1'b0, 3); push(8'hE0, 1'b0, 1'b0, 3);
  endtask

  task automatic add_frame(input int len, input int base);
    logic [15:0] pli, hc, th;
    logic [31:0] c, f;
    bit scr = !cfg_scr_off;
    int rc = (tag_core != 0) ? tag_core : 4;
    int ra = (tag_area != 0) ? tag_area : (cfg_scr_off ? 10 : 5);
    int rf = (tag_area != 0) ? tag_area : (cfg_laps ? 7 : 6);
    pli = 16'(len + (cfg_fcs_off ? 4 : 8));
    hc  = m_hec(pli[15:8], pli[7:0]);
    push(pli[15:8] ^ 8'hB6, 1'b1, 1'b0, rc);
    push(pli[7:0]  ^ 8'hAB, 1'b0, 1'b0, rc);
    push(hc[15:8]  ^ 8'h31, 1'b0, 1'b0, rc);
    push(hc[7:0]   ^ 8'hE0, 1'b0, 1'b0, rc);
    th = m_hec(cfg_type_hi, cfg_type_lo);
    push(cfg_type_hi, 1'b0, scr, ra); push(cfg_type_lo, 1'b0, scr, ra);
    push(th[15:8], 1'b0, scr, ra);    push(th[7:0], 1'b0, scr, ra);
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < len; k++) begin
      logic [7:0] d = src_mem[base + k];
      push(d, 1'b0, scr, ra);
      if (cfg_laps) begin
        for (int i = 0; i < 8; i++) begin
          logic fb = c[0] ^ d[i];
          c = c >> 1;
          if (fb) c = c ^ 32'hEDB88320;
        end
      end else begin
        for (int i = 7; i >= 0; i--) begin
          logic fb = c[31] ^ d[i];
          c = c << 1;
          if (fb) c = c ^ 32'h04C11DB7;
        end
      end
    end
    f = ~c;
    if (!cfg_fcs_off) begin
      if (cfg_laps) begin
        push(m_rev(f[7:0]), 1'b0, scr, rf);   push(m_rev(f[15:8]), 1'b0, scr, rf);
        push(m_rev(f[23:16]), 1'b0, scr, rf); push(m_rev(f[31:24]), 1'b0, scr, rf);
      end else begin
        push(f[31:24], 1'b0, scr, rf); push(f[23:16], 1'b0, scr, rf);
        push(f[15:8], 1'b0, scr, rf);  push(f[7:0], 1'b0, scr, rf);
      end
    end
  endtask

  task automatic do_reset(input int nfr);
    rst_n = 1'b0; sink_en = 1'b0; fr_cnt = nfr;
    cap_n = 0; exp_n = 0; m_hist = '0; tag_core = 0; tag_area = 0;
    prev_en = 1'b0; stb_err = 0; hold_err = 0;
    repeat (3) @(negedge clk);
    chk(out_stb === 1'b0 && out_sof === 1'b0 && out_byte === 8'h00 && pkt_take === 1'b0,
        "R1", {out_stb, out_sof, pkt_take, out_byte}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_stb === 1'b0 && out_byte === 8'h00, "R1", {out_stb, out_byte}, 32'h0);
    last_byte = out_byte;
  endtask

  task automatic run(input int cycles, input int pat);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (out_stb === 1'b1) begin
        cap_b[cap_n] = out_byte; cap_s[cap_n] = out_sof; cap_n++;
      end
      if (out_stb !== prev_en) stb_err++;
      if (out_stb === 1'b0 && out_byte !== last_byte) hold_err++;
      last_byte = out_byte;
      case (pat)
        0: sink_en = 1'b1;
        1: sink_en = (c % 3) != 2;
        default: sink_en = !(c >= 10 && c < 16);
      endcase
      prev_en = sink_en;
    end
  endtask

  task automatic compare();
    chk(cap_n >= exp_n, "R2", cap_n, exp_n);
    chk(stb_err == 0, "R2", stb_err, 0);
    chk(hold_err == 0, "R2", hold_err, 0);
    for (int i = 0; i < exp_n; i++) begin
      chk(cap_b[i] === exp_b[i], rname(exp_r[i]), cap_b[i], exp_b[i]);
      chk(cap_s[i] === exp_s[i], rname(exp_r[i]), cap_s[i], exp_s[i]);
    end
  endtask

  task automatic fill_src(input int seed);
    for (int k = 0; k < 64; k++) src_mem[k] = 8'((k * 37 + seed * 11 + 5) & 255);
  endtask

  task automatic set_cfg(input logic fo, input logic lp, input logic so);
    cfg_type_hi = 8'h00; cfg_type_lo = 8'h01;
    cfg_fcs_off = fo; cfg_laps = lp; cfg_scr_off = so;
  endtask

  // R3: only idle frames when nothing is pending
  task automatic t_idle();
    set_cfg(1'b0, 1'b0, 1'b0); fill_src(1);
    fr_len[0] = 0; fr_len[4] = 0;
    do_reset(0);
    run(30, 1);
    repeat (4) add_idle();
    compare();
  endtask

  // R4 R5 R6 R9: one frame with FCS, scrambled, gapped slots
  task automatic t_normal();
    set_cfg(1'b0, 1'b0, 1'b0); fill_src(2);
    cfg_type_hi = 8'h3C; cfg_type_lo = 8'hA5;
    fr_len[0] = 6; fr_len[4] = 0;
    do_reset(1);
    run(70, 1);
    add_frame(6, 0); repeat (5) add_idle();
    compare();
  endtask

  // R7: reflected, bit-reversed FCS
  task automatic t_laps();
    set_cfg(1'b0, 1'b1, 1'b0); fill_src(3);
    fr_len[0] = 7; fr_len[4] = 0;
    do_reset(1);
    run(40, 0);
    add_frame(7, 0); repeat (4) add_idle();
    compare();
  endtask

  // R8: FCS omitted, shorter length indicator
  task automatic t_nofcs();
    set_cfg(1'b1, 1'b1, 1'b0); fill_src(4);
    fr_len[0] = 5; fr_len[4] = 0;
    do_reset(1);
    tag_core = 8; tag_area = 8;
    run(30, 0);
    add_frame(5, 0); repeat (3) add_idle();
    compare();
  endtask

  // R10: bypass then resume with held history, at a boundary
  task automatic t_scr_off();
    set_cfg(1'b0, 1'b0, 1'b1); fill_src(5);
    fr_len[0] = 4; fr_len[1] = 5; fr_len[4] = 0;
    do_reset(1);
    run(24, 0);
    fr_cnt = 2; cfg_scr_off = 1'b0;
    run(40, 0);
    cfg_scr_off = 1'b1; add_frame(4, 0);
    add_idle(); add_idle();
    cfg_scr_off = 1'b0; tag_area = 10; add_frame(5, 4); tag_area = 0;
    add_idle();
    compare();
  endtask

  // R9 R11: back-to-back frames with a stall, history carried over
  task automatic t_back2back();
    set_cfg(1'b0, 1'b0, 1'b0); fill_src(6);
    fr_len[0] = 3; fr_len[1] = 5; fr_len[4] = 0;
    do_reset(2);
    run(60, 2);
    tag_core = 11; tag_area = 9;
    add_frame(3, 0); add_frame(5, 3);
    tag_core = 0; tag_area = 0;
    repeat (4) add_idle();
    compare();
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    fr_cnt = 0;
    for (int k = 0; k < 5; k++) fr_len[k] = 0;
    set_cfg(1'b0, 1'b0, 1'b0);
    t_idle();
    t_normal();
    t_laps();
    t_nofcs();
    t_scr_off();
    t_back2back();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule